// File: doc/BRIEF.md
# Drive Bay Indicator Blink Controller

This block drives the indicator LEDs of a small group of storage drive bays. Each bay has three indicators: activity, locate and fault. A host writes two kinds of word through a one-cycle write port. The transmit word holds one byte per bay and says what each indicator does. The configuration word sets the rates of two independent 50% duty-cycle blink generators, A and B. Each indicator can be steady off, steady on, or follow one of the generators. When it follows a generator it is lit either in the first half or in the second half of that generator's period.

Time comes from a single-cycle pulse on `tick_i`, which arrives once every eighth of a second. Each generator is a two-state machine:
- `HALF_FIRST` moves to `HALF_SECOND` on a tick when its half-cycle counter has reached the programmed rate code.
- `HALF_SECOND` moves back to `HALF_FIRST` under the same condition.
- From either state, a configuration write (restart) forces `HALF_FIRST` with the counter at zero.

The LED outputs are registered. They take a new value only on a clock edge that follows a tick or a host write, and they then match the updated transmit word and generator states.

Top module: `led_blink_ctrl`

## Requirements
- R1: While reset is low, all LED outputs are 0. After reset the transmit word is zero, both rate codes are zero and both generators are in `HALF_FIRST`.
- R2: Drive d (0..3) uses transmit bits [8*(3-d)+7 : 8*(3-d)], so drive 0 is in bits 31:24 and drive 3 in bits 7:0. Within a byte, activity is in bits 7:5, locate in bits 4:3 and fault in bits 2:0. Output bit d of each LED vector belongs to drive d.
- R3: For an activity or fault code, 0 is off and 1 is steady on. Codes 4 and 5 are off.
- R4: Activity or fault code 2 is lit while generator A is in its first half. Code 3 is lit while generator A is in its second half.
- R5: Activity or fault code 6 is lit while generator B is in its first half. Code 7 is lit while generator B is in its second half.
- R6: Locate code 0 is off, 1 is steady on, 2 is lit in generator A's first half, and 3 is lit in generator A's second half.
- R7: Configuration bits 11:8 hold rate code nA and bits 15:12 hold rate code nB. Each half-cycle of a generator lasts n+1 ticks, so a full blink period is 2(n+1) ticks.
- R8: A configuration write restarts both generators in `HALF_FIRST` with a zero count. A tick in the same cycle as that write is ignored.
- R9: LED outputs change only one clock after a cycle that has a tick or a write. In all other cycles they hold, whatever the generator settings.
- R10: `wr_sel_i`=0 selects the configuration word and `wr_sel_i`=1 selects the transmit word. All configuration bits other than 15:8 are ignored. Writes and ticks in the same cycle both take effect, except as stated in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse every 1/8 s |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 1 | 0: configuration word, 1: transmit word |
| wr_data_i | input | 32 | Host write data |
| act_led_o | output | 4 | Activity LED per drive (bit d = drive d) |
| loc_led_o | output | 4 | Locate LED per drive |
| err_led_o | output | 4 | Fault LED per drive |

## Verification
The bench aims at these corner cases:
- **Half-cycle boundary at the shortest and longest rate codes.** An off-by-one counter would stretch or shrink the period, and lead and lag modes would drift apart from their generator.
- **A configuration write in the same cycle as a tick.** A design that counted that tick would leave the restarted generator one tick ahead.
- **Codes 4 and 5, and junk in the unused configuration bits.** A loose decoder would light an LED or pick up a wrong rate.
- **Drive byte order.** A reversed byte order would light a bay other than the one addressed.

A behavioural reference model of counters and phases is compared against every LED output on every clock.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    typedef enum logic {
        HALF_FIRST  = 1'b0,
        HALF_SECOND = 1'b1
    } half_e;

    localparam int CFG_RATE_A_LSB = 8;
    localparam int CFG_RATE_B_LSB = 12;
    localparam int BYTE_W         = 8;

    // Lit decision for a 3-bit activity/fault code (locate is zero-extended).
    function automatic logic ind_lit(input logic [2:0] code,
                                     input logic       a_first,
                                     input logic       b_first);
        logic lit;
        case (code)
            3'd1:    lit = 1'b1;
            3'd2:    lit = a_first;
            3'd3:    lit = !a_first;
            3'd6:    lit = b_first;
            3'd7:    lit = !b_first;
            default: lit = 1'b0;
        endcase
        return lit;
    endfunction

endpackage

// File: rtl/blink_gen.sv
module blink_gen
    import led_blink_pkg::*;
#(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              restart_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              first_nxt_o
);

    half_e             half_q, half_d;
    logic [RATE_W-1:0] cnt_q, cnt_d;
    logic              at_end;

    assign at_end = (cnt_q == rate_i);

    always_comb begin
        half_d = half_q;
        cnt_d  = cnt_q;
        if (restart_i) begin
            half_d = HALF_FIRST;
            cnt_d  = '0;
        end else if (tick_i) begin
            if (at_end) begin
                cnt_d = '0;
                unique case (half_q)
                    HALF_FIRST:  half_d = HALF_SECOND;
                    HALF_SECOND: half_d = HALF_FIRST;
                endcase
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= HALF_FIRST;
            cnt_q  <= '0;
        end else begin
            half_q <= half_d;
            cnt_q  <= cnt_d;
        end
    end

    always_comb first_nxt_o = (half_d == HALF_FIRST);

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= rate_i);

    // R7
    half_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !restart_i && at_end) |=> (half_q != $past(half_q)));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (half_q == HALF_FIRST && cnt_q == '0));

    // R9
    gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> ($stable(half_q) && $stable(cnt_q)));

endmodule

// File: rtl/drive_led_decode.sv
module drive_led_decode
    import led_blink_pkg::*;
(
    input  logic [BYTE_W-1:0] cfg_byte_i,
    input  logic              a_first_i,
    input  logic              b_first_i,
    output logic              act_o,
    output logic              loc_o,
    output logic              err_o
);

    logic [2:0] act_code;
    logic [1:0] loc_code;
    logic [2:0] err_code;

    assign act_code = cfg_byte_i[7:5];
    assign loc_code = cfg_byte_i[4:3];
    assign err_code = cfg_byte_i[2:0];

    always_comb begin
        act_o = ind_lit(act_code, a_first_i, b_first_i);
        loc_o = ind_lit({1'b0, loc_code}, a_first_i, b_first_i);
        err_o = ind_lit(err_code, a_first_i, b_first_i);
    end

endmodule

// File: rtl/led_host_regs.sv
module led_host_regs
    import led_blink_pkg::*;
#(
    parameter int TX_W   = 32,
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [TX_W-1:0]   wr_data_i,
    output logic [TX_W-1:0]   tx_nxt_o,
    output logic [RATE_W-1:0] rate_a_o,
    output logic [RATE_W-1:0] rate_b_o,
    output logic              restart_o
);

    logic [TX_W-1:0] tx_q;
    logic            cfg_wr, tx_wr;

    assign cfg_wr    = wr_en_i && !wr_sel_i;
    assign tx_wr     = wr_en_i && wr_sel_i;
    assign restart_o = cfg_wr;
    assign tx_nxt_o  = tx_wr ? wr_data_i : tx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q     <= '0;
            rate_a_o <= '0;
            rate_b_o <= '0;
        end else begin
            tx_q <= tx_nxt_o;
            if (cfg_wr) begin
                rate_a_o <= wr_data_i[CFG_RATE_A_LSB +: RATE_W];
                rate_b_o <= wr_data_i[CFG_RATE_B_LSB +: RATE_W];
            end
        end
    end

    // R10
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(rate_a_o) && $stable(rate_b_o)));

endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
    import led_blink_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int RATE_W     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  wr_en_i,
    input  logic                  wr_sel_i,
    input  logic [NUM_DRIVES*8-1:0] wr_data_i,
    output logic [NUM_DRIVES-1:0] act_led_o,
    output logic [NUM_DRIVES-1:0] loc_led_o,
    output logic [NUM_DRIVES-1:0] err_led_o
);

    localparam int TX_W = NUM_DRIVES * BYTE_W;

    logic [TX_W-1:0]       tx_nxt;
    logic [RATE_W-1:0]     rate_a, rate_b;
    logic                  restart;
    logic                  a_first, b_first;
    logic                  upd;
    logic [NUM_DRIVES-1:0] act_d, loc_d, err_d;

    led_host_regs #(.TX_W(TX_W), .RATE_W(RATE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .tx_nxt_o  (tx_nxt),
        .rate_a_o  (rate_a),
        .rate_b_o  (rate_b),
        .restart_o (restart)
    );

    blink_gen #(.RATE_W(RATE_W)) u_gen_a (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .restart_i   (restart),
        .rate_i      (rate_a),
        .first_nxt_o (a_first)
    );

    blink_gen #(.RATE_W(RATE_W)) u_gen_b (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .restart_i   (restart),
        .rate_i      (rate_b),
        .first_nxt_o (b_first)
    );

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
        localparam int SLOT = NUM_DRIVES - 1 - d;
        drive_led_decode u_dec (
            .cfg_byte_i (tx_nxt[SLOT*BYTE_W +: BYTE_W]),
            .a_first_i  (a_first),
            .b_first_i  (b_first),
            .act_o      (act_d[d]),
            .loc_o      (loc_d[d]),
            .err_o      (err_d[d])
        );
    end

    assign upd = tick_i || wr_en_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_led_o <= '0;
            loc_led_o <= '0;
            err_led_o <= '0;
        end else if (upd) begin
            act_led_o <= act_d;
            loc_led_o <= loc_d;
            err_led_o <= err_d;
        end
    end

    // R9
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(act_led_o) && $stable(loc_led_o) && $stable(err_led_o)));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i && wr_data_i == '0)
        |=> (act_led_o == '0 && loc_led_o == '0 && err_led_o == '0));

endmodule

// File: tb/led_blink_ctrl_test.sv
`timescale 1ns/1ps
module led_blink_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        wr_sel_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [3:0]  act_led_o, loc_led_o, err_led_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int m_tx = 0;
    int m_rate[2];
    int m_cnt[2];
    int m_half[2];   // 0 = first half, 1 = second half

    always #4 clk = ~clk;

    led_blink_ctrl uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .act_led_o(act_led_o), .loc_led_o(loc_led_o), .err_led_o(err_led_o)
    );

    function automatic bit lit(int code, int ha, int hb);
        if (code == 1) return 1;
        if (code == 2) return ha == 0;
        if (code == 3) return ha == 1;
        if (code == 6) return hb == 0;
        if (code == 7) return hb == 1;
        return 0;
    endfunction

    function automatic logic [11:0] model_leds();
        logic [3:0] a, l, e;
        for (int d = 0; d < 4; d++) begin
            int b;
            b = (m_tx >> (8 * (3 - d))) & 'hFF;
            a[d] = lit((b >> 5) & 7, m_half[0], m_half[1]);
            l[d] = lit((b >> 3) & 3, m_half[0], m_half[1]);
            e[d] = lit(b & 7, m_half[0], m_half[1]);
        end
        return {a, l, e};
    endfunction

    task automatic compare(string tag);
        logic [11:0] exp_v, act_v;
        exp_v = model_leds();
        act_v = {act_led_o, loc_led_o, err_led_o};
        checks++;
        if (act_v !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic step(bit tk, bit we, bit sel, logic [31:0] data, string tag);
        @(negedge clk);
        tick_i = tk; wr_en_i = we; wr_sel_i = sel; wr_data_i = data;
        @(posedge clk);
        if (we && !sel) begin
            m_rate[0] = int'(data[11:8]);
            m_rate[1] = int'(data[15:12]);
            for (int g = 0; g < 2; g++) begin m_cnt[g] = 0; m_half[g] = 0; end
        end else if (tk) begin
            for (int g = 0; g < 2; g++) begin
                if (m_cnt[g] == m_rate[g]) begin
                    m_cnt[g] = 0; m_half[g] = 1 - m_half[g];
                end else m_cnt[g]++;
            end
        end
        if (we && sel) m_tx = int'(data);
        @(negedge clk);
        tick_i = 0; wr_en_i = 0; wr_sel_i = 0; wr_data_i = '0;
        compare(tag);
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, '0, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < 2; g++) begin m_rate[g] = 0; m_cnt[g] = 0; m_half[g] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 during reset");
        rst_n = 1;
        @(negedge clk);
        compare("R1 after reset");
        ticks(3, "R1 idle after reset stays off");

        // steady on everywhere: act=1 loc=1 err=1 -> 0x29
        step(0, 1, 1, 32'h29292929, "R3 steady on all drives");
        ticks(4, "R3 steady on holds");
        // byte order: only drive 0
        step(0, 1, 1, 32'h29000000, "R2 drive0 in top byte");
        checks++;
        if (act_led_o !== 4'b0001) begin
            failures++;
            $display("FAIL R2 act actual=%b expected=0001", act_led_o);
        end
        step(0, 1, 1, 32'h00000029, "R2 drive3 in low byte");
        checks++;
        if (err_led_o !== 4'b1000) begin
            failures++;
            $display("FAIL R2 err actual=%b expected=1000", err_led_o);
        end
        // codes 4 and 5 off
        step(0, 1, 1, 32'h85A4_85A4, "R3 codes 4 and 5 are off");
        ticks(6, "R3 codes 4 and 5 stay off");
        step(0, 1, 1, 32'h0, "R3 clear");

        // generator A rate 2, B rate 0
        step(0, 1, 0, 32'h0000_0200, "R7 config A=2 B=0");
        // d0: act2 loc3 err6 ; d1: act3 loc2 err7 ; d2: act6 loc0 err2 ; d3: act7 loc1 err3
        step(0, 1, 1, {8'b010_11_110, 8'b011_10_111, 8'b110_00_010, 8'b111_01_011},
             "R4 R5 R6 mixed modes");
        ticks(20, "R4 R5 R6 R7 blink A=2 B=0");

        // restart with simultaneous tick
        ticks(1, "R7 mid period");
        step(1, 1, 0, 32'h0000_1300, "R8 restart with tick ignored");
        ticks(12, "R8 after restart A=3 B=1");

        // no tick, no write: hold
        for (int i = 0; i < 5; i++) step(0, 0, 0, '0, "R9 hold without tick");

        // tick and transmit write together
        step(1, 1, 1, 32'h4C4C_4C4C, "R10 tick plus transmit write");
        // junk config bits ignored, A=15 B=15
        step(0, 1, 0, 32'hABCD_FFFF, "R10 junk config bits");
        step(0, 1, 1, {8'b010_10_110, 8'b011_11_111, 8'b010_10_110, 8'b011_11_111},
             "R7 long rate modes");
        ticks(70, "R7 rate 15 period");
        step(0, 1, 0, 32'h0000_0000, "R7 rate 0");
        ticks(6, "R7 rate 0 toggles every tick");

        // mixed stress
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 99);
            step(r < 60, r >= 90, (r % 2) == 1, $urandom, "R9 R10 stress");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule